// File: doc/BRIEF.md
# Indirect DLL register access port

This block gives a host a narrow window onto a private bank of 64 internal 32-bit words. The host sees four 32-bit port registers at fixed byte offsets. To reach an internal word, software does three things in order. It sets the direction and the internal address in the mode port. For a write, it loads the data word into the write-data port. It then pulses the start bit high and back low. The block performs exactly one internal access per pulse. For a read, it latches the addressed word into the result port, where software collects it.

Internal writes are guarded by a write-protect lock. The lock opens only while internal word 0 holds the unlock code 0xA5000000. Word 0 itself can always be written. A write to any other word while the lock is closed is dropped and raises a sticky error flag. The flag is visible in the start/status port.

The port map is as follows:
- 0x14 is write data.
- 0x16 is start/status: bit 0 is the start bit, bit 1 is the error flag.
- 0x18 is mode/address: bit 8 is the direction, bits 5:0 are the internal address.
- 0x1C is the read result.

Top module: `dllport_top`

## Requirements
- R1: After reset the lock is closed, the error flag is 0, every internal word is 0, and all four ports read 0.
- R2: In the mode port (offset 0x18), bit 8 set to 1 selects an internal read and 0 selects a write. The internal address is bits 5:0, and bits 7:6 and 31:9 have no effect on the access. Reading the mode port returns only bits 8 and 5:0.
- R3: An internal write stores the word that is held in the write-data port (offset 0x14) at the moment of the start. Reading the write-data port returns the last value written to it.
- R4: An access is launched only when bit 0 of the start port (offset 0x16) changes from 0 to 1. Writing 1 again while the bit is already 1 launches no access. Reading the start port returns the start bit in bit 0.
- R5: A read access loads the addressed word into the result port (offset 0x1C). The result port then holds that value through later write accesses until the next read access.
- R6: While the lock is closed, an internal write to any address other than 0 leaves that word unchanged. Such a write also sets bit 1 of the start port, which stays at 1 until reset.
- R7: A write of 0xA5000000 to internal address 0 opens the lock, so later writes to other addresses take effect. A write of any other value to address 0 closes the lock again. Word 0 always stores the written value.
- R8: A host read at any offset other than 0x14, 0x16, 0x18 or 0x1C returns 0.
- R9: Host reads return their data on rdata in the cycle after rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered host read data |

## Verification
The bench builds the block with its default parameters:
- an 8-bit host offset;
- 32-bit words;
- a 6-bit internal address, which gives 64 words;
- the direction bit at position 8.

With these values, the top word 63 is reachable. A mode value with bits 7:6 set shows that those bits alias onto the 6-bit address. The direction bit sits directly above the unused gap, so a wrong field boundary turns a write into a read, or sends it to the wrong word.

// File: rtl/dllport_pkg.sv
package dllport_pkg;
  localparam int OFF_WDATA = 'h14;
  localparam int OFF_CTRL  = 'h16;
  localparam int OFF_MODE  = 'h18;
  localparam int OFF_RES   = 'h1C;
  localparam logic [31:0] UNLOCK_CODE = 32'hA500_0000;
endpackage

// File: rtl/dllport_host_regs.sv
module dllport_host_regs
  import dllport_pkg::*;
#(
  parameter int HA_W    = 8,
  parameter int DW      = 32,
  parameter int IAW     = 6,
  parameter int DIR_BIT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [HA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   result,
  input  logic            err,
  output logic [DW-1:0]   rdata_q,
  output logic            go_q,
  output logic            dir_q,
  output logic [IAW-1:0]  ia_q,
  output logic [DW-1:0]   wd_q
);
  logic            start_q;
  logic [DW-1:0]   rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      HA_W'(OFF_WDATA): rd_mux = wd_q;
      HA_W'(OFF_CTRL): begin
        rd_mux[0] = start_q;
        rd_mux[1] = err;
      end
      HA_W'(OFF_MODE): begin
        rd_mux[DIR_BIT]   = dir_q;
        rd_mux[IAW-1:0]   = ia_q;
      end
      HA_W'(OFF_RES): rd_mux = result;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      go_q    <= 1'b0;
      dir_q   <= 1'b0;
      ia_q    <= '0;
      wd_q    <= '0;
      rdata_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          HA_W'(OFF_WDATA): wd_q <= wdata;
          HA_W'(OFF_CTRL): begin
            start_q <= wdata[0];
            go_q    <= wdata[0] & ~start_q;
          end
          HA_W'(OFF_MODE): begin
            dir_q <= wdata[DIR_BIT];
            ia_q  <= wdata[IAW-1:0];
          end
          default: ;
        endcase
      end
      if (rd_en) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/dllport_access_seq.sv
module dllport_access_seq
  import dllport_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           dir,
  input  logic [IAW-1:0] ia,
  input  logic [DW-1:0]  wd,
  output logic           mem_we,
  output logic           mem_re,
  output logic           locked_q,
  output logic           err_q
);
  logic is_wr;
  logic to_zero;

  assign is_wr   = go & ~dir;
  assign to_zero = (ia == '0);
  assign mem_we  = is_wr & (~locked_q | to_zero);
  assign mem_re  = go & dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      if (is_wr && to_zero) locked_q <= (wd != DW'(UNLOCK_CODE));
      if (is_wr && locked_q && !to_zero) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dllport_reg_array.sv
module dllport_reg_array #(
  parameter int DW  = 32,
  parameter int IAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           re,
  input  logic [IAW-1:0] a,
  input  logic [DW-1:0]  wd,
  output logic [DW-1:0]  rd_q
);
  localparam int DEPTH = 1 << IAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (we) mem[a] <= wd;
      if (re) rd_q <= mem[a];
    end
  end
endmodule

// File: rtl/dllport_top.sv
module dllport_top #(
  parameter int HA_W    = 8,
  parameter int DW      = 32,
  parameter int IAW     = 6,
  parameter int DIR_BIT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [HA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic           go_w, dir_w, we_w, re_w, locked_w, err_w;
  logic [IAW-1:0] ia_w;
  logic [DW-1:0]  wd_w, res_w;

  dllport_host_regs #(.HA_W(HA_W), .DW(DW), .IAW(IAW), .DIR_BIT(DIR_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .result(res_w), .err(err_w), .rdata_q(rdata),
    .go_q(go_w), .dir_q(dir_w), .ia_q(ia_w), .wd_q(wd_w)
  );

  dllport_access_seq #(.DW(DW), .IAW(IAW)) u_seq (
    .clk(clk), .rst(rst), .go(go_w), .dir(dir_w), .ia(ia_w), .wd(wd_w),
    .mem_we(we_w), .mem_re(re_w), .locked_q(locked_w), .err_q(err_w)
  );

  dllport_reg_array #(.DW(DW), .IAW(IAW)) u_mem (
    .clk(clk), .rst(rst), .we(we_w), .re(re_w), .a(ia_w), .wd(wd_w),
    .rd_q(res_w)
  );
endmodule

// File: rtl/dllport_chk.sv
module dllport_chk
  import dllport_pkg::*;
#(
  parameter int HA_W = 8,
  parameter int DW   = 32,
  parameter int IAW  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic [HA_W-1:0] addr,
  input logic [DW-1:0]   rdata,
  input logic            go,
  input logic            dir,
  input logic [IAW-1:0]  ia,
  input logic [DW-1:0]   wd,
  input logic            locked,
  input logic            err
);
  logic mapped;
  assign mapped = (addr == HA_W'(OFF_WDATA)) || (addr == HA_W'(OFF_CTRL)) ||
                  (addr == HA_W'(OFF_MODE))  || (addr == HA_W'(OFF_RES));

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (locked && !err && rdata == '0));

  a_r4_single_launch: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r6_locked_write_flags: assert property (@(posedge clk) disable iff (rst)
    (go && !dir && locked && ia != '0) |=> err);

  a_r7_code_opens: assert property (@(posedge clk) disable iff (rst)
    (go && !dir && ia == '0 && wd == DW'(UNLOCK_CODE)) |=> !locked);

  a_r7_other_closes: assert property (@(posedge clk) disable iff (rst)
    (go && !dir && ia == '0 && wd != DW'(UNLOCK_CODE)) |=> locked);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);
endmodule

bind dllport_top dllport_chk #(.HA_W(HA_W), .DW(DW), .IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .go(go_w), .dir(dir_w), .ia(ia_w), .wd(wd_w), .locked(locked_w), .err(err_w)
);

// File: tb/sim_dllport_top.sv
module sim_dllport_top;
  localparam logic [7:0] P_WD = 8'h14, P_CT = 8'h16, P_MD = 8'h18, P_RS = 8'h1C;
  localparam int NV = 8;
  // {dir, ia[5:0], data, expected}
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 6'd0,  32'hA500_0000, 32'h0},
    {1'b0, 6'd5,  32'h1111_2222, 32'h0},
    {1'b0, 6'd63, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 6'd5,  32'h0,         32'h1111_2222},
    {1'b1, 6'd63, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 6'd0,  32'h0,         32'hA500_0000},
    {1'b0, 6'd5,  32'h0,         32'h0},
    {1'b1, 6'd5,  32'h0,         32'h0}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dllport_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic access(input logic [31:0] mode, input logic [31:0] d);
    if (!mode[8]) hw(P_WD, d);
    hw(P_MD, mode);
    hw(P_CT, 32'h1);
    hw(P_CT, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state, R9 read latency
    hr(P_WD, r); check("R1 wdata port", r, 0);
    hr(P_CT, r); check("R1 ctrl port", r, 0);
    hr(P_MD, r); check("R1 mode port", r, 0);
    hr(P_RS, r); check("R9 R1 result port", r, 0);
    access(32'h100 | 32'd10, 0); hr(P_RS, r); check("R1 word10 zero", r, 0);

    // R6 locked write ignored, sticky error
    access(32'd9, 32'h5555_AAAA);
    hr(P_CT, r); check("R6 error flag", r, 32'h2);
    access(32'h109, 0); hr(P_RS, r); check("R6 word9 unchanged", r, 0);

    // table walk: R7 unlock, R3 writes, R5 reads
    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      access({23'd0, v[70], 2'b00, v[69:64]}, v[63:32]);
      if (v[70]) begin
        hr(P_RS, r); check($sformatf("R5 R3 vector %0d", i), r, v[31:0]);
      end
    end
    hr(P_CT, r); check("R6 error stays set", r, 32'h2);

    // R4 start only on rising edge
    hw(P_WD, 32'hAAAA_0001); hw(P_MD, 32'd5); hw(P_CT, 32'h1);
    hw(P_WD, 32'hBBBB_0002); hw(P_CT, 32'h1); hw(P_CT, 32'h1);
    hr(P_CT, r); check("R4 start bit readback", r, 32'h3);
    hw(P_CT, 32'h0);
    access(32'h105, 0); hr(P_RS, r); check("R4 single launch", r, 32'hAAAA_0001);

    // R5 result held through a write access
    access(32'd6, 32'h7777_7777); hr(P_RS, r); check("R5 result held", r, 32'hAAAA_0001);
    hr(P_WD, r); check("R3 wdata readback", r, 32'h7777_7777);

    // R2 alias of bits 7:6 and upper bits, mode readback
    access(32'hFFFF_FEFF, 32'h0BAD_F00D);
    access(32'h13F, 0); hr(P_RS, r); check("R2 alias to 63", r, 32'h0BAD_F00D);
    hw(P_MD, 32'hFFFF_FFFF); hr(P_MD, r); check("R2 mode readback", r, 32'h13F);

    // R8 unmapped offsets
    hr(8'h10, r); check("R8 offset 0x10", r, 0);
    hr(8'h1A, r); check("R8 offset 0x1A", r, 0);
    hr(8'h00, r); check("R8 offset 0x00", r, 0);

    // R7 relock with another code
    access(32'd0, 32'h1234_5678);
    access(32'd5, 32'hCAFE_CAFE);
    access(32'h105, 0); hr(P_RS, r); check("R7 relocked word5", r, 32'hAAAA_0001);
    access(32'h100, 0); hr(P_RS, r); check("R7 word0 stored", r, 32'h1234_5678);

    finish_run();
  end
endmodule